// File: doc/BRIEF.md
# Parallel Port Service Request Logic

This block decides when a parallel port controller asks its host for attention. Two internal sources can raise a request: the channel control state machine and the data pipeline. Each one delivers a single-cycle event pulse. The first event sets a pending latch, which drives the active-low service request pin low. The latch also records which source asked. Later events from either source only add to the recorded sources.

The request is withdrawn in two cases. The first is the start of a hardware acknowledge cycle, signalled by a one-cycle strobe. The second is any change of the interrupt-enable control bit between two consecutive cycles. Withdrawing clears the pending bit and the source bits together.

A DMA request input is registered and driven out on a second active-low pin. Two host-readable registers give a polled view of the block. The request-source register shows the pending bit and the two source bits. The read-only status register shows the inverse of both request pins.

Top module: `svc_req_top`

## Requirements
- R1: While synchronous reset is high and on the first clock after it, both request pins are high and both registers read 0x00.
- R2: A source event in a cycle with no acknowledge strobe and no change of the enable bit sets the pending bit (request register bit 7) on the next clock, and the service request pin goes low.
- R3: Request register bit 1 records a channel-controller event (srcEvt[1]) and bit 0 records a data-pipeline event (srcEvt[0]); if both events arrive together, both bits are set.
- R4: While the request is pending, source bits stay set, and a new event ORs its bit into them.
- R5: An acknowledge strobe clears the pending bit and both source bits on the next clock, and the service request pin returns high.
- R6: When an acknowledge strobe and a source event arrive in the same cycle, the clear wins and that event is lost; the register still reads 0x00 one cycle later.
- R7: A change of the enable bit in either direction clears the request exactly as an acknowledge does, and this clear also wins over a same-cycle event; an enable bit held at one value, high or low, clears nothing.
- R8: Status register bit 3 reads 1 exactly when the service request pin is low, and bit 7 reads 1 exactly when the DMA request pin is low; all its other bits read 0.
- R9: The DMA request pin is the inverse of the DMA request input, delayed by one clock.
- R10: Request register bits 6 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcEvt | input | 2 | Request events; bit 1 is the channel controller, bit 0 is the data pipeline |
| ack | input | 1 | Single-cycle hardware acknowledge strobe |
| intEn | input | 1 | Interrupt-enable control bit |
| dmaReq | input | 1 | DMA request, active high |
| svcReqN | output | 1 | Service request pin, active low |
| dmaReqN | output | 1 | DMA request pin, active low |
| reqRd | output | 8 | Request-source register read value |
| statRd | output | 8 | Status register read value |

## Verification
The pending latch drives both the request pin and two register bits. A pending bit stuck or cleared at the wrong time therefore shows in three places, one clock after the event, strobe or enable change that should have moved it. Wrong source tracking shows as the wrong low bits in the request register on the clock after the event. Such an error can hide until an acknowledge arrives, because the sources are sticky. The scoreboard compares all four outputs on every cycle, so a wrong priority between clear and set appears within one cycle.

// File: rtl/svc_req_pkg.sv
package svc_req_pkg;
  localparam int SRC_N    = 2;
  localparam int PEND_BIT = 7;
  localparam int DMA_BIT  = 7;
  localparam int SRP_BIT  = 3;

  typedef struct packed {
    logic             clr;
    logic [SRC_N-1:0] set;
    logic             dmaVal;
  } strb_t;
endpackage

// File: rtl/svc_req_ctrl.sv
module svc_req_ctrl
  import svc_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] srcEvt,
  input  logic             ack,
  input  logic             intEn,
  input  logic             dmaReq,
  output strb_t            strb
);
  logic intEnQ;
  logic enToggle;

  // The enable history follows the pin during reset, so leaving reset is not a toggle.
  always_ff @(posedge clk) begin
    intEnQ <= intEn;
  end

  assign enToggle = intEn ^ intEnQ;

  always_comb begin
    strb.clr    = ack | enToggle;
    strb.set    = strb.clr ? '0 : srcEvt;
    strb.dmaVal = dmaReq;
    if (rst) begin
      strb.clr = 1'b1;
      strb.set = '0;
    end
  end
endmodule

// File: rtl/svc_req_dp.sv
module svc_req_dp
  import svc_req_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strb_t            strb,
  output logic             svcReqN,
  output logic             dmaReqN,
  output logic [REG_W-1:0] reqRd,
  output logic [REG_W-1:0] statRd
);
  logic             pend;
  logic [SRC_N-1:0] srcQ;
  logic             dmaQ;

  always_ff @(posedge clk) begin
    if (rst || strb.clr) pend <= 1'b0;
    else if (|strb.set)  pend <= 1'b1;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst || strb.clr)  srcQ[g] <= 1'b0;
      else if (strb.set[g]) srcQ[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dmaQ <= 1'b0;
    else     dmaQ <= strb.dmaVal;
  end

  assign svcReqN = ~pend;
  assign dmaReqN = ~dmaQ;

  always_comb begin
    reqRd                = '0;
    reqRd[PEND_BIT]      = pend;
    reqRd[SRC_N-1:0]     = srcQ;
    statRd               = '0;
    statRd[DMA_BIT]      = dmaQ;
    statRd[SRP_BIT]      = pend;
  end
endmodule

// File: rtl/svc_req_top.sv
module svc_req_top
  import svc_req_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] srcEvt,
  input  logic             ack,
  input  logic             intEn,
  input  logic             dmaReq,
  output logic             svcReqN,
  output logic             dmaReqN,
  output logic [REG_W-1:0] reqRd,
  output logic [REG_W-1:0] statRd
);
  strb_t strb;

  svc_req_ctrl ctrl_i (
    .clk(clk), .rst(rst), .srcEvt(srcEvt), .ack(ack),
    .intEn(intEn), .dmaReq(dmaReq), .strb(strb)
  );

  svc_req_dp #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .svcReqN(svcReqN),
    .dmaReqN(dmaReqN), .reqRd(reqRd), .statRd(statRd)
  );
endmodule

// File: rtl/svc_req_chk.sv
module svc_req_chk
  import svc_req_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [SRC_N-1:0] srcEvt,
  input logic             ack,
  input logic             intEn,
  input logic             dmaReq,
  input logic             svcReqN,
  input logic             dmaReqN,
  input logic [REG_W-1:0] reqRd,
  input logic [REG_W-1:0] statRd
);
  localparam logic [REG_W-1:0] RSV_MASK =
    ~(({{(REG_W-1){1'b0}}, 1'b1} << PEND_BIT) | {{(REG_W-SRC_N){1'b0}}, {SRC_N{1'b1}}});

  // R2
  set_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (|srcEvt && !ack && intEn == $past(intEn)) |=> (!svcReqN && reqRd[PEND_BIT]));

  // R4
  sticky_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!svcReqN && !ack && intEn == $past(intEn)) |=>
      ((reqRd[SRC_N-1:0] & $past(reqRd[SRC_N-1:0])) == $past(reqRd[SRC_N-1:0])));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> (svcReqN && reqRd[SRC_N-1:0] == '0));

  // R7
  toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (intEn != $past(intEn)) |=> (svcReqN && reqRd[SRC_N-1:0] == '0));

  // R8
  srp_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    statRd[SRP_BIT] == reqRd[PEND_BIT]);

  // R9
  dma_pin_chk: assert property (@(posedge clk) disable iff (rst)
    dmaReq |=> (!dmaReqN && statRd[DMA_BIT]));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reqRd & RSV_MASK) == '0);
endmodule

bind svc_req_top svc_req_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/svc_req_top_tb_top.sv
`timescale 1ns/100ps
module svc_req_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] srcEvt = '0;
  logic       ack = 1'b0;
  logic       intEn = 1'b0;
  logic       dmaReq = 1'b0;
  logic       svcReqN, dmaReqN;
  logic [7:0] reqRd, statRd;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       svcN;
    logic       dmaN;
    logic [7:0] req;
    logic [7:0] stat;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  logic       mPend = 1'b0;
  logic [1:0] mSrc = '0;
  logic       mDma = 1'b0;
  logic       mEnPrev = 1'b0;

  always #2 clk = ~clk;

  svc_req_top dut_i (
    .clk(clk), .rst(rst), .srcEvt(srcEvt), .ack(ack), .intEn(intEn),
    .dmaReq(dmaReq), .svcReqN(svcReqN), .dmaReqN(dmaReqN),
    .reqRd(reqRd), .statRd(statRd)
  );

  task automatic push_exp(input string tag);
    exp_t e;
    e.svcN = ~mPend;
    e.dmaN = ~mDma;
    e.req  = {mPend, 5'b00000, mSrc};
    e.stat = {mDma, 3'b000, mPend, 3'b000};
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  task automatic step(input logic [1:0] evt, input logic a, input logic en,
                      input logic d, input string tag);
    logic clr;
    @(negedge clk);
    srcEvt = evt; ack = a; intEn = en; dmaReq = d;
    clr = a | (en != mEnPrev);
    if (clr) begin
      mPend = 1'b0;
      mSrc  = '0;
    end else if (|evt) begin
      mPend = 1'b1;
      mSrc  = mSrc | evt;
    end
    mEnPrev = en;
    mDma    = d;
    @(posedge clk);
    #0.5;
    push_exp(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nChk++;
      if (svcReqN !== e.svcN || dmaReqN !== e.dmaN || reqRd !== e.req || statRd !== e.stat) begin
        nFail++;
        $display("FAIL %s: actual svcN=%b dmaN=%b req=%h stat=%h expected svcN=%b dmaN=%b req=%h stat=%h",
                 e.tag, svcReqN, dmaReqN, reqRd, statRd, e.svcN, e.dmaN, e.req, e.stat);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #0.5;
    push_exp("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #0.5;
    push_exp("R1 after reset");

    step(2'b01, 0, 0, 0, "R2 R3 pipeline event sets pending");
    step(2'b00, 0, 0, 0, "R4 R10 pending held, reserved zero");
    step(2'b10, 0, 0, 0, "R4 channel ORs into sources");
    step(2'b00, 1, 0, 0, "R5 ack clears");
    step(2'b11, 0, 0, 0, "R3 both sources together");
    step(2'b10, 1, 0, 0, "R6 ack beats event");
    step(2'b00, 0, 0, 0, "R6 dropped event stays lost");
    step(2'b10, 0, 0, 0, "R2 R3 channel event");
    step(2'b00, 0, 1, 0, "R7 enable rise clears");
    step(2'b01, 0, 1, 0, "R7 enable held high, event sets");
    step(2'b00, 0, 1, 0, "R7 enable held high no clear");
    step(2'b10, 0, 0, 0, "R7 enable fall beats event");
    step(2'b00, 0, 0, 1, "R9 R8 dma pin low");
    step(2'b01, 0, 0, 1, "R8 both status bits");
    step(2'b00, 0, 0, 0, "R9 dma pin high");
    step(2'b00, 1, 0, 0, "R5 ack with nothing pending");
    step(2'b00, 0, 0, 0, "R10 idle");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule